// File: doc/BRIEF.md
# Keyed configuration data port

This block gives boot firmware a narrow window onto a table of configuration items. The host writes a 16-bit key into a control register to choose an item. It then pulls that item's bytes out of a byte-wide data register one at a time, and an internal offset advances after each byte. Items live in two banks of sixteen entries: a generic bank and an architecture-local bank. Each entry has its own byte storage and a length.

A key flag turns the chosen entry into a write channel. The host then pushes bytes into the entry. When the last byte lands, the block emits a one-cycle completion strobe that names the bank and index of the entry, and the offset rewinds to zero. A side port loads entry bytes and lengths before the host starts. After reset, generic entry 0 holds a four-character signature and generic entry 1 holds a 32-bit identifier.

Top module: `cfg_key_port`

## Requirements
- R1: A word write (`bus_wide`=1) to control address 0 selects the written key and clears the byte offset to 0.
- R2: Key bit 15 picks the architecture-local bank (1) or the generic bank (0). Key bit 14 marks a write channel. Key bits 13:0 are the entry index, and each bank has `ENTRIES` (16) entries.
- R3: If a select carries an index (bits 13:0) of `ENTRIES` or more, the current key becomes 0xFFFF (invalid), and later data reads return 0.
- R4: A byte read at data address `DATA_ADDR` (1) returns the current entry's byte at the offset on `bus_rdata` one clock after the read strobe, and the offset advances by one. `bus_rdata` changes only on data reads.
- R5: A data read returns 0 and leaves the offset unchanged when the key is invalid, the entry length is 0, or the offset is at or past the length.
- R6: A byte write at the data address stores the byte at the offset and advances the offset, but only when key bit 14 is set, the key is valid and the offset is below the length. In every other case the write does nothing.
- R7: When a write brings the offset up to the entry length, `done_pulse` is high for exactly the next cycle, with `done_bank`/`done_index` giving the entry, and the offset returns to 0.
- R8: Reset selects key 0 with offset 0 and clears all entries. It then loads generic entry 0 with the 4 signature bytes "BOOT" (read in the order B, O, O, T) and generic entry 1 with the identifier 1, least significant byte first (01 00 00 00). Both entries get length 4.
- R9: The preload port writes a byte (`pl_byte_we`) or a length (`pl_len_we`) into the entry named by `pl_key`, using the same bank/index fields as R2. Lengths above `ENTRY_BYTES` (8) are clamped to 8. Indices of `ENTRIES` or more are ignored and do not alias onto other entries.
- R10: A byte write to the control address, a word write to the data address, and a read of the control address change neither the key, the offset nor `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 2 | Register address: 0 control, DATA_ADDR data |
| bus_wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| bus_wdata | input | 16 | Write data (key, or byte in bits 7:0) |
| bus_rdata | output | 8 | Registered read data |
| pl_byte_we | input | 1 | Preload a byte |
| pl_len_we | input | 1 | Preload a length |
| pl_key | input | 16 | Preload target, key format |
| pl_off | input | log2(ENTRY_BYTES) | Preload byte position |
| pl_byte | input | 8 | Preload byte value |
| pl_len | input | 16 | Preload length value |
| done_pulse | output | 1 | Write channel filled |
| done_bank | output | 1 | Bank of the filled entry |
| done_index | output | log2(ENTRIES) | Index of the filled entry |

## Verification
Every host result appears one rising edge after its strobe. A read's byte shows on `bus_rdata`, a select or an access moves the offset, and a filling write raises the completion strobe, all in the cycle that follows. The bench drives every stimulus at a falling edge. A behavioural model updates at the next rising edge, and the bench compares all outputs against it at the following falling edge, which is exactly the cycle where each result is due. Ignored accesses are followed by data reads, so any stray change of key or offset shows up in the bytes that come back.

// File: rtl/cfg_key_port.sv
module cfg_key_port #(
  parameter int ENTRIES = 16,
  parameter int ENTRY_BYTES = 8,
  parameter int DATA_ADDR = 1,
  parameter logic [31:0] SIGNATURE = 32'h424F_4F54,
  parameter logic [31:0] ID_VALUE = 32'd1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_wr,
  input  logic bus_rd,
  input  logic [1:0] bus_addr,
  input  logic bus_wide,
  input  logic [15:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic pl_byte_we,
  input  logic pl_len_we,
  input  logic [15:0] pl_key,
  input  logic [$clog2(ENTRY_BYTES)-1:0] pl_off,
  input  logic [7:0] pl_byte,
  input  logic [15:0] pl_len,
  output logic done_pulse,
  output logic done_bank,
  output logic [$clog2(ENTRIES)-1:0] done_index
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int OFF_W = $clog2(ENTRY_BYTES);
  localparam int SLOTS = 2 * ENTRIES;
  localparam int DEPTH = SLOTS * ENTRY_BYTES;
  localparam logic [15:0] KEY_BAD = 16'hFFFF;
  localparam logic [15:0] LEN_MAX = 16'(ENTRY_BYTES);

  logic [15:0] key_q, off_q;
  logic [7:0]  mem [DEPTH];
  logic [15:0] len_q [SLOTS];

  wire sel_hit = bus_wr && bus_wide && bus_addr == 2'd0;
  wire dat_rd  = bus_rd && bus_addr == DATA_ADDR[1:0];
  wire dat_wr  = bus_wr && !bus_wide && bus_addr == DATA_ADDR[1:0];
  wire sel_ok  = bus_wdata[13:0] < 14'(ENTRIES);

  wire [IDX_W:0] cur_slot = {key_q[15], key_q[IDX_W-1:0]};
  wire [15:0] cur_len = len_q[cur_slot];
  wire key_ok = key_q != KEY_BAD;
  wire in_range = key_ok && off_q < cur_len;
  wire rd_ok = dat_rd && in_range;
  wire wr_ok = dat_wr && in_range && key_q[14];
  wire [IDX_W+OFF_W:0] cur_addr = {cur_slot, off_q[OFF_W-1:0]};
  wire [15:0] off_nx = off_q + 16'd1;

  wire pl_ok = pl_key[13:0] < 14'(ENTRIES);
  wire [IDX_W:0] pl_slot = {pl_key[15], pl_key[IDX_W-1:0]};
  wire [15:0] pl_len_c = (pl_len > LEN_MAX) ? LEN_MAX : pl_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q <= '0;
      off_q <= '0;
      bus_rdata <= '0;
      done_pulse <= 1'b0;
      done_bank <= 1'b0;
      done_index <= '0;
      for (int s = 0; s < DEPTH; s++) mem[s] <= 8'h00;
      for (int s = 0; s < SLOTS; s++) len_q[s] <= 16'd0;
      for (int k = 0; k < 4; k++) begin
        mem[k] <= SIGNATURE[31-8*k -: 8];
        mem[ENTRY_BYTES+k] <= ID_VALUE[8*k +: 8];
      end
      len_q[0] <= 16'd4;
      len_q[1] <= 16'd4;
    end else begin
      done_pulse <= 1'b0;
      if (pl_byte_we && pl_ok) mem[{pl_slot, pl_off}] <= pl_byte;
      if (pl_len_we && pl_ok) len_q[pl_slot] <= pl_len_c;
      if (sel_hit) begin
        off_q <= '0;
        key_q <= sel_ok ? bus_wdata : KEY_BAD;
      end
      if (dat_rd) begin
        bus_rdata <= rd_ok ? mem[cur_addr] : 8'h00;
        if (rd_ok) off_q <= off_nx;
      end
      if (wr_ok) begin
        mem[cur_addr] <= bus_wdata[7:0];
        if (off_nx == cur_len) begin
          off_q <= '0;
          done_pulse <= 1'b1;
          done_bank <= key_q[15];
          done_index <= key_q[IDX_W-1:0];
        end else begin
          off_q <= off_nx;
        end
      end
    end
  end
endmodule

// File: rtl/cfg_key_port_chk.sv
module cfg_key_port_chk #(
  parameter int ENTRIES = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sel_hit,
  input logic dat_rd,
  input logic dat_wr,
  input logic [15:0] bus_wdata,
  input logic [15:0] key_q,
  input logic [15:0] off_q,
  input logic [15:0] cur_len,
  input logic [7:0] bus_rdata,
  input logic done_pulse
);
  AST_SELECT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> off_q == 16'd0); // R1
  AST_BAD_INDEX_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && bus_wdata[13:0] >= 14'(ENTRIES)) |=> key_q == 16'hFFFF); // R3
  AST_STALL_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd && (key_q == 16'hFFFF || off_q >= cur_len)) |=> ($stable(off_q) && bus_rdata == 8'h00)); // R5
  AST_RO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !key_q[14]) |=> $stable(off_q)); // R6
  AST_FILL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> ($past(dat_wr) && off_q == 16'd0)); // R7
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (key_q == 16'd0 && off_q == 16'd0)); // R8
endmodule

bind cfg_key_port cfg_key_port_chk #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/sim_cfg_key_port.sv
`timescale 1ns/1ps
module sim_cfg_key_port;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic bus_wr = 0, bus_rd = 0, bus_wide = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic pl_byte_we = 0, pl_len_we = 0;
  logic [15:0] pl_key = 0;
  logic [2:0] pl_off = 0;
  logic [7:0] pl_byte = 0;
  logic [15:0] pl_len = 0;
  logic done_pulse, done_bank;
  logic [3:0] done_index;

  cfg_key_port u0 (.*);

  int checks = 0, errors = 0;
  string cur_req = "R8";
  bit finished = 0;

  int m_mem [2][16][8];
  int m_len [2][16];
  int m_key = 0, m_off = 0;
  int e_rdata = 0, e_done = 0, e_bank = 0, e_idx = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    string sig = "BOOT";
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 16; i++) begin
        m_len[b][i] = 0;
        for (int o = 0; o < 8; o++) m_mem[b][i][o] = 0;
      end
    for (int k = 0; k < 4; k++) m_mem[0][0][k] = sig[k];
    m_mem[0][1][0] = 1;
    m_len[0][0] = 4;
    m_len[0][1] = 4;
    m_key = 0; m_off = 0; e_rdata = 0; e_done = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int b, i;
      bit ok;
      e_done = 0;
      if (pl_key[13:0] < 16) begin
        if (pl_byte_we) m_mem[pl_key[15]][pl_key[3:0]][pl_off] = pl_byte;
        if (pl_len_we) m_len[pl_key[15]][pl_key[3:0]] = (pl_len > 8) ? 8 : pl_len;
      end
      b = (m_key >> 15) & 1;
      i = m_key & 16'h3FFF;
      ok = (m_key != 16'hFFFF) && (m_off < m_len[b][i & 15]);
      if (bus_wr && bus_wide && bus_addr == 0) begin
        m_off = 0;
        m_key = (bus_wdata[13:0] < 16) ? bus_wdata : 16'hFFFF;
      end else if (bus_rd && bus_addr == 1) begin
        if (ok) begin
          e_rdata = m_mem[b][i][m_off];
          m_off++;
        end else e_rdata = 0;
      end else if (bus_wr && !bus_wide && bus_addr == 1 && ok && m_key[14]) begin
        m_mem[b][i][m_off] = bus_wdata[7:0];
        m_off++;
        if (m_off == m_len[b][i]) begin
          m_off = 0; e_done = 1; e_bank = b; e_idx = i;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(bus_rdata == e_rdata[7:0], cur_req, "rdata", bus_rdata, e_rdata);
      check(done_pulse == e_done[0], "R7", "done_pulse", done_pulse, e_done);
      if (e_done) begin
        check(done_bank == e_bank[0], "R7", "done_bank", done_bank, e_bank);
        check(done_index == e_idx[3:0], "R7", "done_index", done_index, e_idx);
      end
    end
  end

  task automatic bus_op(bit wr, bit rd, bit wide, logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_wide = 0;
  endtask
  task automatic select(logic [15:0] k); bus_op(1, 0, 1, 2'd0, k); endtask
  task automatic rd(); bus_op(0, 1, 0, 2'd1, 16'h0); endtask
  task automatic wr(logic [7:0] v); bus_op(1, 0, 0, 2'd1, {8'h00, v}); endtask

  task automatic pl_b(logic [15:0] k, int o, logic [7:0] v);
    @(negedge clk);
    pl_byte_we = 1; pl_key = k; pl_off = o[2:0]; pl_byte = v;
    @(negedge clk);
    pl_byte_we = 0;
  endtask
  task automatic pl_l(logic [15:0] k, logic [15:0] n);
    @(negedge clk);
    pl_len_we = 1; pl_key = k; pl_len = n;
    @(negedge clk);
    pl_len_we = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(bus_rdata == 8'h00 && done_pulse == 1'b0, "R8", "reset outputs", {bus_rdata, 7'b0, done_pulse}, 0);

    cur_req = "R8"; repeat (4) rd();
    cur_req = "R5"; rd(); rd();
    cur_req = "R1"; select(16'h0001); repeat (4) rd();
    cur_req = "R3"; select(16'h0020); rd(); select(16'h0010); rd(); rd();

    cur_req = "R9";
    pl_b(16'h0005, 0, 8'hA1); pl_b(16'h0005, 1, 8'hB2); pl_b(16'h0005, 2, 8'hC3); pl_l(16'h0005, 3);
    pl_b(16'h8005, 0, 8'h5A); pl_b(16'h8005, 1, 8'h6B); pl_l(16'h8005, 2);
    cur_req = "R2"; select(16'h0005); repeat (4) rd(); select(16'h8005); repeat (3) rd();
    cur_req = "R4"; select(16'h0005); rd(); rd();

    cur_req = "R9";
    pl_b(16'h0010, 0, 8'hEE); pl_l(16'h0010, 4); select(16'h0000); rd();
    pl_l(16'h0007, 16'd20);
    for (int k = 0; k < 8; k++) pl_b(16'h0007, k, 8'(k * 17 + 3));
    select(16'h0007); repeat (9) rd();

    cur_req = "R5"; select(16'h0009); rd();

    cur_req = "R7";
    pl_l(16'h8003, 3); select(16'hC003);
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    select(16'h8003); repeat (4) rd();

    cur_req = "R6";
    select(16'h8003); wr(8'h99); select(16'h8003); rd();
    select(16'h4009); wr(8'h77); select(16'h0009); rd();
    select(16'h4020); wr(8'h55); rd();

    cur_req = "R10";
    select(16'h0005); rd();
    bus_op(1, 0, 0, 2'd0, 16'h0007); rd();
    bus_op(0, 1, 0, 2'd0, 16'h0000); rd();
    select(16'hC003); bus_op(1, 0, 1, 2'd1, 16'h00FE);
    select(16'h8003); rd();

    cur_req = "R8";
    select(16'h0003);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd(); rd();
    select(16'h0005); rd();

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule